// File: doc/BRIEF.md
# Transfer Ring Doorbell Consumer

This block is the device-side consumer for one channel's circular transfer ring. The ring itself sits in host memory. Before use, software loads the ring's base address, its size in elements and a starting index, and the read and write indices both take that index. From then on the host adds work by filling elements, then writing a doorbell that carries its new write index. While the read index differs from the write index, the block reads one 16-byte element at a time through a request/response memory port.

Each element holds a buffer address, a byte length and control bits. An element whose chain flag is set continues into the next element, so a run of chained elements closed by an unchained one forms a single descriptor. For every finished descriptor the block emits one completion pulse. The pulse carries the index where the descriptor started, its summed byte length and the number of elements it used. The read index advances one step per element consumed and wraps at the programmed size.

Top module: `xfer_ring_consumer`

## Requirements
- R1: While reset is applied and after it, `ring_rp` and `ring_wp` are 0, `db_err` is 0, and neither `rd_req_valid` nor `cpl_valid` is high.
- R2: A `cfg_load` pulse captures `cfg_base` and `cfg_size`, sets both `ring_rp` and `ring_wp` to `cfg_start`, clears `db_err`, and drops any partly gathered descriptor. A doorbell in the same cycle as a load is not applied.
- R3: A doorbell whose `db_wp` is below the programmed size sets `ring_wp` to `db_wp` from the next cycle on.
- R4: A doorbell whose `db_wp` is equal to or above the programmed size leaves `ring_wp` unchanged and sets `db_err`. `db_err` then stays set until the next `cfg_load`, and later valid doorbells are still applied.
- R5: No element read is requested while `ring_rp` equals `ring_wp` (empty ring). After a doorbell makes them differ, a read is requested.
- R6: The request address is `base + ring_rp * 16`. While `rd_req_ready` is low, the request and its address hold steady.
- R7: `rd_rsp_data` is decoded as follows: bits [63:0] are the buffer address, bits [95:64] are the byte length, and bits [127:96] are control. Bit 96 is the chain flag. No other control bit has any effect.
- R8: Each element response advances `ring_rp` by one in the cycle after it, and `ring_rp` wraps from size-1 to 0.
- R9: The element whose chain flag is clear ends the descriptor. One cycle after its response, `cpl_valid` is high for exactly one cycle. At that point `cpl_start` is the descriptor's first index, `cpl_bytes` is the sum of its lengths and `cpl_elems` is its element count.
- R10: If a chain reaches the write index, the block stops fetching with the descriptor left open. After the next doorbell it continues the same descriptor, keeping its start index and its running totals.
- R11: At most one element read is outstanding. No new request is raised until the response to the previous one has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_load | input | 1 | Load ring setup and restart indices |
| cfg_base | input | ADDR_W | Byte address of ring element 0 |
| cfg_size | input | PTR_W+1 | Ring size in elements |
| cfg_start | input | PTR_W | Starting read and write index |
| db_valid | input | 1 | Doorbell write strobe |
| db_wp | input | PTR_W | Write index carried by the doorbell |
| rd_req_valid | output | 1 | Element read request |
| rd_req_addr | output | ADDR_W | Byte address of the element to read |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_rsp_valid | input | 1 | Element data returned |
| rd_rsp_data | input | 128 | Element contents |
| cpl_valid | output | 1 | One-cycle descriptor completion pulse |
| cpl_start | output | PTR_W | Index of the descriptor's first element |
| cpl_bytes | output | BYTES_W | Summed byte length of the descriptor |
| cpl_elems | output | PTR_W+1 | Element count of the descriptor |
| ring_rp | output | PTR_W | Current read index |
| ring_wp | output | PTR_W | Current write index |
| db_err | output | 1 | Sticky flag for an out-of-range doorbell |

## Verification
The properties rely on four things about the block's surroundings. The memory returns exactly one response for each accepted request, and never returns an unrequested one. The host never uses a doorbell to pull the write index back onto the read index while elements are still pending. `cfg_load` is applied only when no element read is outstanding. `cfg_start` lies inside a ring of at least two elements. The stimulus meets all four: its memory model answers only requests it has accepted, with a latency of one to three cycles. Every reload is preceded by a wait for the ring to go idle. Every doorbell moves the write index forward without overtaking the read index, and the one deliberately bad doorbell value exercises only the range check.

// File: rtl/xrc_pkg.sv
package xrc_pkg;
  localparam int unsigned ELEM_W     = 128;
  localparam int unsigned ELEM_SHIFT = 4;
  localparam int unsigned CHAIN_BIT  = 0;

  typedef struct packed {
    logic [31:0] ctrl;
    logic [31:0] len;
    logic [63:0] buf_ptr;
  } ring_elem_t;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2
  } fetch_state_t;
endpackage

// File: rtl/xrc_ring_ptrs.sv
module xrc_ring_ptrs #(
  parameter int unsigned PTR_W = 8,
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [CNT_W-1:0] cfg_size,
  input  logic [PTR_W-1:0] cfg_start,
  input  logic             db_valid,
  input  logic [PTR_W-1:0] db_wp,
  input  logic             adv,
  output logic [PTR_W-1:0] rp,
  output logic [PTR_W-1:0] wp,
  output logic             err,
  output logic             empty
);
  logic [PTR_W-1:0] rp_q, rp_d, wp_q, wp_d;
  logic [CNT_W-1:0] size_q, size_d;
  logic             err_q, err_d;
  logic             en;
  logic             db_in_range;
  logic             at_last;

  assign db_in_range = ({1'b0, db_wp} < size_q);
  assign at_last     = ({1'b0, rp_q} == (size_q - CNT_W'(1)));
  assign en          = cfg_load | db_valid | adv;

  always_comb begin
    rp_d   = rp_q;
    wp_d   = wp_q;
    err_d  = err_q;
    size_d = size_q;
    if (cfg_load) begin
      rp_d   = cfg_start;
      wp_d   = cfg_start;
      err_d  = 1'b0;
      size_d = cfg_size;
    end else begin
      if (db_valid) begin
        if (db_in_range) wp_d = db_wp;
        else             err_d = 1'b1;
      end
      if (adv) rp_d = at_last ? '0 : rp_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp_q   <= '0;
      wp_q   <= '0;
      err_q  <= 1'b0;
      size_q <= '0;
    end else if (en) begin
      rp_q   <= rp_d;
      wp_q   <= wp_d;
      err_q  <= err_d;
      size_q <= size_d;
    end
  end

  assign rp    = rp_q;
  assign wp    = wp_q;
  assign err   = err_q;
  assign empty = (rp_q == wp_q);
endmodule

// File: rtl/xrc_fetch_ctrl.sv
module xrc_fetch_ctrl
  import xrc_pkg::*;
#(
  parameter int unsigned PTR_W  = 8,
  parameter int unsigned ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic              empty,
  input  logic [PTR_W-1:0]  rp,
  input  logic              req_ready,
  input  logic              rsp_valid,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic              take
);
  fetch_state_t      st_q, st_d;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] offset;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      FS_IDLE: if (!empty)    st_d = FS_REQ;
      FS_REQ:  if (req_ready) st_d = FS_WAIT;
      FS_WAIT: if (rsp_valid) st_d = FS_IDLE;
      default:                st_d = FS_IDLE;
    endcase
    if (cfg_load) st_d = FS_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= FS_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        base_q <= '0;
    else if (cfg_load) base_q <= cfg_base;
  end

  assign offset    = ADDR_W'(rp) << ELEM_SHIFT;
  assign req_valid = (st_q == FS_REQ);
  assign req_addr  = base_q + offset;
  assign take      = (st_q == FS_WAIT) && rsp_valid && !cfg_load;
endmodule

// File: rtl/xrc_desc_acc.sv
module xrc_desc_acc
  import xrc_pkg::*;
#(
  parameter int unsigned PTR_W   = 8,
  parameter int unsigned BYTES_W = 40,
  localparam int unsigned CNT_W  = PTR_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_load,
  input  logic               take,
  input  logic [ELEM_W-1:0]  rsp_data,
  input  logic [PTR_W-1:0]   rp,
  output logic               cpl_valid,
  output logic [PTR_W-1:0]   cpl_start,
  output logic [BYTES_W-1:0] cpl_bytes,
  output logic [CNT_W-1:0]   cpl_elems
);
  ring_elem_t         elem;
  logic               chain;
  logic               unused_elem_bits;

  logic               open_q, open_d;
  logic [PTR_W-1:0]   start_q, start_d;
  logic [BYTES_W-1:0] sum_q, sum_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               cv_q, cv_d;
  logic [PTR_W-1:0]   cs_q, cs_d;
  logic [BYTES_W-1:0] cb_q, cb_d;
  logic [CNT_W-1:0]   ce_q, ce_d;

  logic [PTR_W-1:0]   start_now;
  logic [BYTES_W-1:0] sum_now;
  logic [CNT_W-1:0]   cnt_now;
  logic               en;

  assign elem             = ring_elem_t'(rsp_data);
  assign chain            = elem.ctrl[CHAIN_BIT];
  assign unused_elem_bits = ^{elem.buf_ptr, elem.ctrl[31:1]};

  assign start_now = open_q ? start_q : rp;
  assign sum_now   = (open_q ? sum_q : '0) + BYTES_W'(elem.len);
  assign cnt_now   = (open_q ? cnt_q : '0) + CNT_W'(1);
  assign en        = cfg_load | take;

  always_comb begin
    open_d  = open_q;
    start_d = start_q;
    sum_d   = sum_q;
    cnt_d   = cnt_q;
    cv_d    = 1'b0;
    cs_d    = cs_q;
    cb_d    = cb_q;
    ce_d    = ce_q;
    if (cfg_load) begin
      open_d = 1'b0;
    end else if (take) begin
      if (chain) begin
        open_d  = 1'b1;
        start_d = start_now;
        sum_d   = sum_now;
        cnt_d   = cnt_now;
      end else begin
        open_d = 1'b0;
        cv_d   = 1'b1;
        cs_d   = start_now;
        cb_d   = sum_now;
        ce_d   = cnt_now;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cv_q <= 1'b0;
    else        cv_q <= cv_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      start_q <= '0;
      sum_q   <= '0;
      cnt_q   <= '0;
      cs_q    <= '0;
      cb_q    <= '0;
      ce_q    <= '0;
    end else if (en) begin
      open_q  <= open_d;
      start_q <= start_d;
      sum_q   <= sum_d;
      cnt_q   <= cnt_d;
      cs_q    <= cs_d;
      cb_q    <= cb_d;
      ce_q    <= ce_d;
    end
  end

  assign cpl_valid = cv_q;
  assign cpl_start = cs_q;
  assign cpl_bytes = cb_q;
  assign cpl_elems = ce_q;
endmodule

// File: rtl/xfer_ring_consumer.sv
module xfer_ring_consumer
  import xrc_pkg::*;
#(
  parameter int unsigned PTR_W   = 8,
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned BYTES_W = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_load,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [PTR_W:0]     cfg_size,
  input  logic [PTR_W-1:0]   cfg_start,
  input  logic               db_valid,
  input  logic [PTR_W-1:0]   db_wp,
  output logic               rd_req_valid,
  output logic [ADDR_W-1:0]  rd_req_addr,
  input  logic               rd_req_ready,
  input  logic               rd_rsp_valid,
  input  logic [ELEM_W-1:0]  rd_rsp_data,
  output logic               cpl_valid,
  output logic [PTR_W-1:0]   cpl_start,
  output logic [BYTES_W-1:0] cpl_bytes,
  output logic [PTR_W:0]     cpl_elems,
  output logic [PTR_W-1:0]   ring_rp,
  output logic [PTR_W-1:0]   ring_wp,
  output logic               db_err
);
  logic [1:0] rst_sync_q;
  logic       core_rst_n;
  logic       empty;
  logic       take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  xrc_ring_ptrs #(.PTR_W(PTR_W)) u_ptrs (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .cfg_load  (cfg_load),
    .cfg_size  (cfg_size),
    .cfg_start (cfg_start),
    .db_valid  (db_valid),
    .db_wp     (db_wp),
    .adv       (take),
    .rp        (ring_rp),
    .wp        (ring_wp),
    .err       (db_err),
    .empty     (empty)
  );

  xrc_fetch_ctrl #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_fetch (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .cfg_load  (cfg_load),
    .cfg_base  (cfg_base),
    .empty     (empty),
    .rp        (ring_rp),
    .req_ready (rd_req_ready),
    .rsp_valid (rd_rsp_valid),
    .req_valid (rd_req_valid),
    .req_addr  (rd_req_addr),
    .take      (take)
  );

  xrc_desc_acc #(.PTR_W(PTR_W), .BYTES_W(BYTES_W)) u_acc (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .cfg_load  (cfg_load),
    .take      (take),
    .rsp_data  (rd_rsp_data),
    .rp        (ring_rp),
    .cpl_valid (cpl_valid),
    .cpl_start (cpl_start),
    .cpl_bytes (cpl_bytes),
    .cpl_elems (cpl_elems)
  );
endmodule

// File: rtl/xrc_checker.sv
module xrc_checker #(
  parameter int unsigned PTR_W  = 8,
  parameter int unsigned ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_load,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              rd_rsp_valid,
  input logic              cpl_valid,
  input logic [PTR_W-1:0]  ring_rp,
  input logic [PTR_W-1:0]  ring_wp,
  input logic              db_err
);
  logic outst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          outst_q <= 1'b0;
    else if (cfg_load)                   outst_q <= 1'b0;
    else if (rd_req_valid && rd_req_ready) outst_q <= 1'b1;
    else if (rd_rsp_valid)               outst_q <= 1'b0;
  end

  // R4: the error flag holds until a reload
  a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    db_err && !cfg_load |=> db_err);

  // R5: never fetch from an empty ring
  a_r5_no_fetch_empty: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (ring_rp != ring_wp));

  // R6: a stalled request keeps its address
  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready && !cfg_load |=> rd_req_valid && $stable(rd_req_addr));

  // R8: one step or a wrap per response
  a_r8_rp_step: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_valid && outst_q && !cfg_load |=>
      (ring_rp == '0) || (ring_rp == $past(ring_rp) + PTR_W'(1)));

  // R9: completion is a single-cycle pulse
  a_r9_cpl_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |=> !cpl_valid);

  // R11: a single read in flight
  a_r11_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> !outst_q);
endmodule

bind xfer_ring_consumer xrc_checker #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_load     (cfg_load),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_addr  (rd_req_addr),
  .rd_rsp_valid (rd_rsp_valid),
  .cpl_valid    (cpl_valid),
  .ring_rp      (ring_rp),
  .ring_wp      (ring_wp),
  .db_err       (db_err)
);

// File: tb/sim_xfer_ring_consumer.sv
module sim_xfer_ring_consumer;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;
  localparam int AW = 64;
  localparam int BW = 40;
  localparam int WATCHDOG = 20000;

  logic          clk;
  logic          rst_n;
  logic          cfg_load;
  logic [AW-1:0] cfg_base;
  logic [PW:0]   cfg_size;
  logic [PW-1:0] cfg_start;
  logic          db_valid;
  logic [PW-1:0] db_wp;
  logic          rd_req_valid;
  logic [AW-1:0] rd_req_addr;
  logic          rd_req_ready;
  logic          rd_rsp_valid;
  logic [127:0]  rd_rsp_data;
  logic          cpl_valid;
  logic [PW-1:0] cpl_start;
  logic [BW-1:0] cpl_bytes;
  logic [PW:0]   cpl_elems;
  logic [PW-1:0] ring_rp;
  logic [PW-1:0] ring_wp;
  logic          db_err;

  xfer_ring_consumer #(.PTR_W(PW), .ADDR_W(AW), .BYTES_W(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_base(cfg_base),
    .cfg_size(cfg_size), .cfg_start(cfg_start), .db_valid(db_valid), .db_wp(db_wp),
    .rd_req_valid(rd_req_valid), .rd_req_addr(rd_req_addr), .rd_req_ready(rd_req_ready),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data), .cpl_valid(cpl_valid),
    .cpl_start(cpl_start), .cpl_bytes(cpl_bytes), .cpl_elems(cpl_elems),
    .ring_rp(ring_rp), .ring_wp(ring_wp), .db_err(db_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int vecs = 0;
  int fails = 0;
  int cyc = 0;
  int cpl_cnt = 0;
  int last_start = -1;
  longint last_bytes = -1;
  int last_elems = -1;

  // host memory model
  logic [127:0] mem [0:255];
  bit  pend = 0;
  int  pcnt = 0;
  int  pidx = 0;

  // reference model state
  int            m_rp = 0, m_wp = 0, m_size = 0;
  bit            m_err = 0, m_open = 0;
  int            m_start = 0, m_cnt = 0;
  longint        m_sum = 0;
  logic [AW-1:0] m_base = '0;
  bit            e_cpl = 0;
  int            e_start = 0, e_elems = 0;
  longint        e_bytes = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [127:0] mk_elem(input int idx, input int len, input bit chain);
    logic [63:0] p;
    logic [31:0] ctrl;
    p    = 64'h0000_00AB_0000_0000 + 64'(idx) * 64'd4096;
    ctrl = 32'h5A00_0F00 | {31'd0, chain};
    return {ctrl, 32'(len), p};
  endfunction

  // reference model: advances on the same edges the requirements name
  always @(posedge clk) begin
    if (!rst_n) begin
      m_rp = 0; m_wp = 0; m_err = 0; m_open = 0; m_size = 0; e_cpl = 0;
    end else begin
      bit nxt;
      nxt = 0;
      if (cfg_load) begin
        m_rp = int'(cfg_start); m_wp = int'(cfg_start); m_err = 0;
        m_size = int'(cfg_size); m_base = cfg_base; m_open = 0;
      end else begin
        if (rd_rsp_valid) begin
          if (!m_open) begin m_start = m_rp; m_sum = 0; m_cnt = 0; end
          m_sum += longint'(rd_rsp_data[95:64]);
          m_cnt++;
          if (rd_rsp_data[96]) m_open = 1;
          else begin
            m_open = 0; nxt = 1;
            e_start = m_start; e_bytes = m_sum; e_elems = m_cnt;
          end
          m_rp = (m_rp == m_size - 1) ? 0 : m_rp + 1;
        end
        if (db_valid) begin
          if (int'(db_wp) < m_size) m_wp = int'(db_wp);
          else m_err = 1;
        end
      end
      e_cpl = nxt;
    end
  end

  // per-cycle comparison and memory responder, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
    if (rst_n) begin
      chk(ring_rp == PW'(m_rp), "R8 ring_rp", longint'(ring_rp), longint'(m_rp));
      chk(ring_wp == PW'(m_wp), "R3 ring_wp", longint'(ring_wp), longint'(m_wp));
      chk(db_err == m_err, "R4 db_err", longint'(db_err), longint'(m_err));
      chk(cpl_valid == e_cpl, "R9 cpl_valid", longint'(cpl_valid), longint'(e_cpl));
      if (cpl_valid && e_cpl) begin
        chk(cpl_start == PW'(e_start), "R9 cpl_start", longint'(cpl_start), longint'(e_start));
        chk(cpl_bytes == BW'(e_bytes), "R7 cpl_bytes", longint'(cpl_bytes), e_bytes);
        chk(cpl_elems == (PW+1)'(e_elems), "R9 cpl_elems", longint'(cpl_elems), longint'(e_elems));
      end
      if (cpl_valid) begin
        cpl_cnt++;
        last_start = int'(cpl_start); last_bytes = longint'(cpl_bytes); last_elems = int'(cpl_elems);
      end
      if (rd_req_valid)
        chk(m_rp != m_wp, "R5 request on empty ring", longint'(m_rp), longint'(m_wp));
    end
    rd_rsp_valid = 1'b0;
    if (pend) begin
      pcnt--;
      if (pcnt == 0) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = mem[pidx];
        pend = 0;
      end
    end
    rd_req_ready = ((cyc % 3) != 1);
    if (rst_n && rd_req_valid && rd_req_ready) begin
      logic [AW-1:0] exp_addr;
      exp_addr = m_base + AW'(m_rp) * AW'(16);
      chk(!pend, "R11 second request outstanding", longint'(pend), 0);
      chk(rd_req_addr == exp_addr, "R6 rd_req_addr", longint'(rd_req_addr), longint'(exp_addr));
      pidx = int'((rd_req_addr - m_base) >> 4) & 255;
      pend = 1;
      pcnt = 1 + (pidx % 3);
    end
  end

  task automatic do_load(input logic [AW-1:0] b, input int sz, input int st);
    @(negedge clk);
    cfg_base = b; cfg_size = (PW+1)'(sz); cfg_start = PW'(st); cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic ring_db(input int wpv);
    @(negedge clk);
    db_valid = 1'b1; db_wp = PW'(wpv);
    @(negedge clk);
    db_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(ring_rp == ring_wp && !rd_req_valid && !pend) && n < 3000);
    repeat (3) @(negedge clk);
  endtask

  localparam logic [AW-1:0] BASE_A = 64'h0000_0001_2345_6000;
  localparam logic [AW-1:0] BASE_B = 64'h0000_0000_0800_0100;

  initial begin
    int c0;
    rst_n = 1'b0; cfg_load = 1'b0; cfg_base = '0; cfg_size = '0; cfg_start = '0;
    db_valid = 1'b0; db_wp = '0; rd_req_ready = 1'b0; rd_rsp_valid = 1'b0; rd_rsp_data = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ring_rp == 0 && ring_wp == 0, "R1 indices in reset", longint'(ring_rp), 0);
    chk(!db_err && !rd_req_valid && !cpl_valid, "R1 flags in reset",
        longint'({db_err, rd_req_valid, cpl_valid}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!rd_req_valid && !cpl_valid, "R1 quiet after reset", longint'(rd_req_valid), 0);

    // wrap plus a chained descriptor: 10 single, 11->0->1 chain
    mem[10] = mk_elem(10, 100, 0);
    mem[11] = mk_elem(11, 200, 1);
    mem[0]  = mk_elem(0, 300, 1);
    mem[1]  = mk_elem(1, 64, 0);
    do_load(BASE_A, 12, 10);
    @(negedge clk);
    chk(ring_rp == 10 && ring_wp == 10, "R2 load sets indices", longint'(ring_rp), 10);
    repeat (5) @(negedge clk);
    chk(!rd_req_valid, "R5 no fetch before doorbell", longint'(rd_req_valid), 0);
    c0 = cpl_cnt;
    ring_db(2);
    wait_idle();
    chk(ring_rp == 2, "R8 wrapped read index", longint'(ring_rp), 2);
    chk(cpl_cnt - c0 == 2, "R9 completions for two descriptors", longint'(cpl_cnt - c0), 2);
    chk(last_start == 11 && last_elems == 3, "R9 chained start", longint'(last_start), 11);
    chk(last_bytes == 564, "R7 chained byte total", last_bytes, 564);

    // R4: out-of-range doorbells, then a valid one while flagged
    ring_db(12);
    @(negedge clk);
    chk(db_err && ring_wp == 2, "R4 bad doorbell ignored", longint'(ring_wp), 2);
    ring_db(255);
    mem[2] = mk_elem(2, 7, 0);
    ring_db(3);
    wait_idle();
    chk(db_err == 1'b1, "R4 error stays set", longint'(db_err), 1);
    chk(ring_rp == 3 && last_bytes == 7, "R4 later doorbell applied", longint'(ring_rp), 3);

    // R10: chain stalls at the write index, resumes on the next doorbell
    mem[3] = mk_elem(3, 10, 1);
    mem[4] = mk_elem(4, 20, 1);
    c0 = cpl_cnt;
    ring_db(5);
    wait_idle();
    chk(cpl_cnt == c0 && ring_rp == 5, "R10 open chain waits", longint'(cpl_cnt - c0), 0);
    mem[5] = mk_elem(5, 30, 0);
    ring_db(6);
    wait_idle();
    chk(last_start == 3 && last_elems == 3, "R10 resumed start", longint'(last_start), 3);
    chk(last_bytes == 60, "R10 resumed byte total", last_bytes, 60);

    // small ring filled to full, reload clears the error
    mem[3] = mk_elem(3, 1000, 0);
    mem[0] = mk_elem(0, 1, 1);
    mem[1] = mk_elem(1, 2, 0);
    do_load(BASE_B, 4, 3);
    @(negedge clk);
    chk(!db_err, "R2 reload clears error", longint'(db_err), 0);
    ring_db(2);
    wait_idle();
    chk(ring_rp == 2 && last_start == 0 && last_bytes == 3, "R8 full ring drained",
        longint'(ring_rp), 2);
    mem[2] = mk_elem(2, 5, 0);
    mem[3] = mk_elem(3, 6, 0);
    ring_db(0);
    wait_idle();
    chk(ring_rp == 0 && last_start == 3, "R8 wrap on size 4", longint'(ring_rp), 0);

    // R2: reload drops a partial descriptor
    mem[0] = mk_elem(0, 40, 1);
    do_load(BASE_A, 12, 0);
    ring_db(1);
    wait_idle();
    mem[5] = mk_elem(5, 9, 0);
    do_load(BASE_A, 12, 5);
    ring_db(6);
    wait_idle();
    chk(last_start == 5 && last_elems == 1 && last_bytes == 9, "R2 partial dropped",
        longint'(last_elems), 1);

    // doorbells arriving while fetching
    for (int i = 6; i < 10; i++) mem[i] = mk_elem(i, 16 * i, 0);
    c0 = cpl_cnt;
    ring_db(8);
    ring_db(10);
    wait_idle();
    chk(ring_rp == 10 && cpl_cnt - c0 == 4, "R3 doorbell during fetch",
        longint'(cpl_cnt - c0), 4);

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule